// File: doc/BRIEF.md
# Descriptor-Chain DMA Command Sequencer

This block is a single-channel engine that walks a linked list of 16-byte command descriptors held in memory. Once started at a descriptor address, it fetches each descriptor through a word-wide memory master port and decodes the operation. It then does one of four things: hands a data transfer to a device-side port through a request/done handshake, moves a 1, 2 or 4-byte word between memory and the descriptor's auxiliary word, does nothing, or stops. When an operation completes, the engine writes the channel status and the residual count back into the descriptor. It then decides whether to interrupt, and either jumps to a branch target or falls through to the next descriptor.

Each descriptor carries three independent two-bit options, for interrupt, branch and wait. Each option is judged against a masked compare of four device status inputs. A pending wait holds the write-back and retries every cycle. The interrupt is a sticky level that stays high until an acknowledge input clears it.

Top module: `desc_dma_seq`

## Requirements
- R1: After reset the status word is zero, `irq_o` is low and neither `mem_req_o` nor `dev_req_o` is asserted.
- R2: `start_i` is accepted only while the channel is inactive. It loads the descriptor pointer from `start_ptr_i` with bits 3:0 cleared, sets the active flag and clears the dead and branch-taken flags. `wake_i` sets the wake flag, and every descriptor fetch clears it. The status word is {active[15], dead[14], wake[13], flush[12], branch-taken[11], 7'b0, device status[3:0]}.
- R3: A descriptor is four little-endian 32-bit words at pointer +0, +4, +8 and +12. Word 0 holds {command[31:16], request count[15:0]}, word 1 the data address and word 2 the auxiliary word. Word 3 holds {transfer status[31:16], residual[15:0]}. Opcode (command bits 15:12) 0 is output-more, 1 output-last, 2 input-more and 3 input-last. For these the device port is requested with the data address, the request count, the direction (`dev_out_o` is 1 for output) and the last flag. When the device reports done, word 3 is written with {status word, `dev_resid_i`} using all four byte enables.
- R4: The channel is killed in four cases: a transfer with key (command bits 10:8) above 3, a transfer with data address 0, a load or store with key 4, 5 or 7, and an opcode of 8 or above. Killing sets dead, clears active and raises the interrupt, without any write-back or device request.
- R5: Each option field (interrupt at command bits 5:4, branch at 3:2, wait at 1:0) reads 0 as never, 1 as if-set, 2 as if-clear and 3 as always. "Set" means (device status AND mask) equals (select value AND mask).
- R6: When the wait option holds after an operation, the engine writes nothing and does not move on until the option stops holding.
- R7: Once the write-back completes, the interrupt option is evaluated. `irq_o` then stays high until `irq_ack_i`, and a new interrupt event in the same cycle as an acknowledge leaves it high.
- R8: Transfers and no-op (opcode 6) take the branch option. When it holds, the pointer becomes the auxiliary word with bits 3:0 cleared and branch-taken is set. Otherwise the pointer advances by 16 and branch-taken is cleared. A no-op writes only the upper half of word 3.
- R9: Load (opcode 5) takes its size from request count bits 2:0: bit 2 set selects 4 bytes at a 4-aligned address, otherwise bit 1 set selects 2 bytes at a 2-aligned address, otherwise 1 byte. The bytes read replace the low bytes of the auxiliary word, which is then written back to word 2. Load always advances and ignores the branch option.
- R10: Store (opcode 4) writes the low bytes of the auxiliary word to the sized, aligned address using byte enables. It writes only the upper half of word 3 and always advances.
- R11: `flush_i` sets the flush flag. Completing an output-last, input-last, load or store clears it after its write-back; more-transfers and no-ops leave it set.
- R12: Stop (opcode 7) clears active without any memory write.
- R13: `start_i` while the channel is active has no effect on the running chain.
- R14: Memory requests hold address and direction until `mem_ack_i`, are word aligned, and never overlap a device request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured when inactive |
| start_ptr_i | input | 32 | First descriptor address |
| flush_i | input | 1 | Sets the flush flag |
| wake_i | input | 1 | Sets the wake flag |
| dev_stat_i | input | 4 | Device status bits for conditions |
| int_mask_i | input | 4 | Interrupt condition mask |
| int_val_i | input | 4 | Interrupt condition value |
| br_mask_i | input | 4 | Branch condition mask |
| br_val_i | input | 4 | Branch condition value |
| wt_mask_i | input | 4 | Wait condition mask |
| wt_val_i | input | 4 | Wait condition value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte enables |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory acknowledge |
| dev_req_o | output | 1 | Device transfer request |
| dev_out_o | output | 1 | 1 for output, 0 for input |
| dev_last_o | output | 1 | Transfer is a last variant |
| dev_addr_o | output | 32 | Transfer data address |
| dev_len_o | output | 16 | Transfer request count |
| dev_done_i | input | 1 | Device transfer done |
| dev_resid_i | input | 16 | Residual count, valid with done |
| irq_o | output | 1 | Sticky interrupt |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| status_o | output | 16 | Channel status word |

## Verification
An acknowledge on `irq_ack_i` can land in the same cycle that the engine raises a new interrupt. The sharpest case is the decode cycle of a killing descriptor. The bench counts the cycles of the three-word fetch, holds the acknowledge high in exactly that decode cycle while an earlier interrupt is still pending, and requires `irq_o` to stay high. A flush pulse meeting the clearing step of a last variant is the same kind of collision, and the design resolves it in favour of the set.

// File: rtl/desc_dma_seq_pkg.sv
package desc_dma_seq_pkg;

    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 16;
    localparam int DSTAT_W    = 4;
    localparam int NCOND      = 3;
    localparam int CI_INT     = 0;
    localparam int CI_BR      = 1;
    localparam int CI_WAIT    = 2;

    localparam logic [3:0] OP_OUT_MORE = 4'd0;
    localparam logic [3:0] OP_OUT_LAST = 4'd1;
    localparam logic [3:0] OP_IN_MORE  = 4'd2;
    localparam logic [3:0] OP_IN_LAST  = 4'd3;
    localparam logic [3:0] OP_STORE    = 4'd4;
    localparam logic [3:0] OP_LOAD     = 4'd5;
    localparam logic [3:0] OP_NOP      = 4'd6;
    localparam logic [3:0] OP_STOP     = 4'd7;

    localparam logic [1:0] MODE_NEVER  = 2'd0;
    localparam logic [1:0] MODE_IFSET  = 2'd1;
    localparam logic [1:0] MODE_IFCLR  = 2'd2;
    localparam logic [1:0] MODE_ALWAYS = 2'd3;

    localparam logic [1:0] SZ_1 = 2'd0;
    localparam logic [1:0] SZ_2 = 2'd1;
    localparam logic [1:0] SZ_4 = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH0, S_FETCH1, S_FETCH2, S_DECODE,
        S_XFER, S_MEMOP, S_HOLD, S_WB_DEP, S_WB_STAT, S_FINISH
    } seq_st_e;

    typedef struct packed {
        logic        is_xfer;
        logic        is_out;
        logic        is_last;
        logic        is_load;
        logic        is_store;
        logic        is_nop;
        logic        is_stop;
        logic        kill;
        logic [1:0]  size;
        logic [31:0] waddr;
    } dec_t;

    typedef struct packed {
        seq_st_e     st;
        logic [31:0] ptr;
        logic [15:0] cmd;
        logic [15:0] reqcnt;
        logic [31:0] daddr;
        logic [31:0] dep;
        logic [15:0] resid;
        logic        active;
        logic        dead;
        logic        wake;
        logic        flush;
        logic        bt;
        logic        irq;
    } seq_t;

    function automatic logic [15:0] pack_status(
        input logic act, input logic dead, input logic wake,
        input logic flush, input logic bt, input logic [DSTAT_W-1:0] dev);
        return {act, dead, wake, flush, bt, {(11-DSTAT_W){1'b0}}, dev};
    endfunction

endpackage

// File: rtl/dseq_cond.sv
module dseq_cond
    import desc_dma_seq_pkg::*;
(
    input  logic [1:0]         mode_i,
    input  logic [DSTAT_W-1:0] dev_i,
    input  logic [DSTAT_W-1:0] mask_i,
    input  logic [DSTAT_W-1:0] val_i,
    output logic               fire_o
);
    logic match;

    always_comb begin
        match = ((dev_i & mask_i) == (val_i & mask_i));
        case (mode_i)
            MODE_NEVER:  fire_o = 1'b0;
            MODE_IFSET:  fire_o = match;
            MODE_IFCLR:  fire_o = !match;
            default:     fire_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dseq_decode.sv
module dseq_decode
    import desc_dma_seq_pkg::*;
(
    input  logic [3:0]  op_i,
    input  logic [2:0]  key_i,
    input  logic [2:0]  cnt_i,
    input  logic [31:0] daddr_i,
    output dec_t        dec_o
);
    logic key_mem_ok;

    always_comb begin
        dec_o = '0;
        // word moves accept keys 0-3 (taken as system) and 6
        key_mem_ok = (key_i <= 3'd3) || (key_i == 3'd6);
        dec_o.is_xfer  = (op_i <= OP_IN_LAST);
        dec_o.is_out   = (op_i == OP_OUT_MORE) || (op_i == OP_OUT_LAST);
        dec_o.is_last  = (op_i == OP_OUT_LAST) || (op_i == OP_IN_LAST);
        dec_o.is_store = (op_i == OP_STORE);
        dec_o.is_load  = (op_i == OP_LOAD);
        dec_o.is_nop   = (op_i == OP_NOP);
        dec_o.is_stop  = (op_i == OP_STOP);

        if (op_i > OP_STOP) begin
            dec_o.kill = 1'b1;
        end else if (dec_o.is_xfer) begin
            dec_o.kill = (key_i > 3'd3) || (daddr_i == 32'd0);
        end else if (dec_o.is_load || dec_o.is_store) begin
            dec_o.kill = !key_mem_ok;
        end

        if (cnt_i[2]) begin
            dec_o.size  = SZ_4;
            dec_o.waddr = {daddr_i[31:2], 2'b00};
        end else if (cnt_i[1]) begin
            dec_o.size  = SZ_2;
            dec_o.waddr = {daddr_i[31:1], 1'b0};
        end else begin
            dec_o.size  = SZ_1;
            dec_o.waddr = daddr_i;
        end
    end
endmodule

// File: rtl/dseq_lane.sv
module dseq_lane
    import desc_dma_seq_pkg::*;
(
    input  logic [1:0]  size_i,
    input  logic [1:0]  lo_i,
    input  logic [31:0] rdata_i,
    input  logic [31:0] dep_i,
    output logic [31:0] ld_dep_o,
    output logic [31:0] st_data_o,
    output logic [3:0]  st_be_o
);
    logic [31:0] shifted;
    logic [4:0]  sh;

    always_comb begin
        sh        = {lo_i, 3'b000};
        shifted   = rdata_i >> sh;
        st_data_o = dep_i << sh;
        case (size_i)
            SZ_4: begin
                ld_dep_o = shifted;
                st_be_o  = 4'b1111;
            end
            SZ_2: begin
                ld_dep_o = {dep_i[31:16], shifted[15:0]};
                st_be_o  = 4'b0011 << lo_i;
            end
            default: begin
                ld_dep_o = {dep_i[31:8], shifted[7:0]};
                st_be_o  = 4'b0001 << lo_i;
            end
        endcase
    end
endmodule

// File: rtl/desc_dma_seq.sv
module desc_dma_seq
    import desc_dma_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [31:0]  start_ptr_i,
    input  logic         flush_i,
    input  logic         wake_i,
    input  logic [3:0]   dev_stat_i,
    input  logic [3:0]   int_mask_i,
    input  logic [3:0]   int_val_i,
    input  logic [3:0]   br_mask_i,
    input  logic [3:0]   br_val_i,
    input  logic [3:0]   wt_mask_i,
    input  logic [3:0]   wt_val_i,
    output logic         mem_req_o,
    output logic         mem_we_o,
    output logic [31:0]  mem_addr_o,
    output logic [31:0]  mem_wdata_o,
    output logic [3:0]   mem_be_o,
    input  logic [31:0]  mem_rdata_i,
    input  logic         mem_ack_i,
    output logic         dev_req_o,
    output logic         dev_out_o,
    output logic         dev_last_o,
    output logic [31:0]  dev_addr_o,
    output logic [15:0]  dev_len_o,
    input  logic         dev_done_i,
    input  logic [15:0]  dev_resid_i,
    output logic         irq_o,
    input  logic         irq_ack_i,
    output logic [15:0]  status_o
);
    localparam logic [31:0] OFS_W1   = 32'(WORD_BYTES);
    localparam logic [31:0] OFS_W2   = 32'(2 * WORD_BYTES);
    localparam logic [31:0] OFS_W3   = 32'(3 * WORD_BYTES);
    localparam logic [31:0] OFS_NEXT = 32'(DESC_BYTES);

    seq_t q, d;
    dec_t dec;
    logic [15:0] stat_word;
    logic [31:0] ld_dep, st_data;
    logic [3:0]  st_be;
    logic        irq_set;

    logic [NCOND-1:0][1:0]         c_mode;
    logic [NCOND-1:0][DSTAT_W-1:0] c_mask;
    logic [NCOND-1:0][DSTAT_W-1:0] c_val;
    logic [NCOND-1:0]              c_fire;

    dseq_decode u_dec (
        .op_i    (q.cmd[15:12]),
        .key_i   (q.cmd[10:8]),
        .cnt_i   (q.reqcnt[2:0]),
        .daddr_i (q.daddr),
        .dec_o   (dec)
    );

    dseq_lane u_lane (
        .size_i    (dec.size),
        .lo_i      (dec.waddr[1:0]),
        .rdata_i   (mem_rdata_i),
        .dep_i     (q.dep),
        .ld_dep_o  (ld_dep),
        .st_data_o (st_data),
        .st_be_o   (st_be)
    );

    always_comb begin
        c_mode[CI_INT]  = q.cmd[5:4];
        c_mode[CI_BR]   = q.cmd[3:2];
        c_mode[CI_WAIT] = q.cmd[1:0];
        c_mask[CI_INT]  = int_mask_i;
        c_mask[CI_BR]   = br_mask_i;
        c_mask[CI_WAIT] = wt_mask_i;
        c_val[CI_INT]   = int_val_i;
        c_val[CI_BR]    = br_val_i;
        c_val[CI_WAIT]  = wt_val_i;
    end

    for (genvar gi = 0; gi < NCOND; gi++) begin : g_cond
        dseq_cond u_cond (
            .mode_i (c_mode[gi]),
            .dev_i  (dev_stat_i),
            .mask_i (c_mask[gi]),
            .val_i  (c_val[gi]),
            .fire_o (c_fire[gi])
        );
    end

    assign stat_word = pack_status(q.active, q.dead, q.wake, q.flush, q.bt, dev_stat_i);

    always_comb begin
        d           = q;
        irq_set     = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_be_o    = '0;
        dev_req_o   = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.ptr    = {start_ptr_i[31:4], 4'b0000};
                    d.active = 1'b1;
                    d.dead   = 1'b0;
                    d.bt     = 1'b0;
                    d.st     = S_FETCH0;
                end
            end
            S_FETCH0: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.ptr;
                if (mem_ack_i) begin
                    d.cmd    = mem_rdata_i[31:16];
                    d.reqcnt = mem_rdata_i[15:0];
                    d.wake   = 1'b0;
                    d.st     = S_FETCH1;
                end
            end
            S_FETCH1: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.ptr + OFS_W1;
                if (mem_ack_i) begin
                    d.daddr = mem_rdata_i;
                    d.st    = S_FETCH2;
                end
            end
            S_FETCH2: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.ptr + OFS_W2;
                if (mem_ack_i) begin
                    d.dep = mem_rdata_i;
                    d.st  = S_DECODE;
                end
            end
            S_DECODE: begin
                if (dec.kill) begin
                    d.dead   = 1'b1;
                    d.active = 1'b0;
                    irq_set  = 1'b1;
                    d.st     = S_IDLE;
                end else if (dec.is_stop) begin
                    d.active = 1'b0;
                    d.st     = S_IDLE;
                end else if (dec.is_xfer) begin
                    d.st = S_XFER;
                end else if (dec.is_load || dec.is_store) begin
                    d.st = S_MEMOP;
                end else begin
                    d.st = S_HOLD;
                end
            end
            S_XFER: begin
                dev_req_o = 1'b1;
                if (dev_done_i) begin
                    d.resid = dev_resid_i;
                    d.st    = S_HOLD;
                end
            end
            S_MEMOP: begin
                mem_req_o   = 1'b1;
                mem_we_o    = dec.is_store;
                mem_addr_o  = {dec.waddr[31:2], 2'b00};
                mem_wdata_o = st_data;
                mem_be_o    = dec.is_store ? st_be : 4'b1111;
                if (mem_ack_i) begin
                    if (dec.is_load) begin
                        d.dep = ld_dep;
                    end
                    d.st = S_HOLD;
                end
            end
            S_HOLD: begin
                if (!c_fire[CI_WAIT]) begin
                    d.st = dec.is_load ? S_WB_DEP : S_WB_STAT;
                end
            end
            S_WB_DEP: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = q.ptr + OFS_W2;
                mem_wdata_o = q.dep;
                mem_be_o    = 4'b1111;
                if (mem_ack_i) begin
                    d.st = S_WB_STAT;
                end
            end
            S_WB_STAT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = q.ptr + OFS_W3;
                mem_wdata_o = {stat_word, q.resid};
                mem_be_o    = dec.is_xfer ? 4'b1111 : 4'b1100;
                if (mem_ack_i) begin
                    d.st = S_FINISH;
                end
            end
            S_FINISH: begin
                if ((dec.is_xfer && dec.is_last) || dec.is_load || dec.is_store) begin
                    d.flush = 1'b0;
                end
                if (c_fire[CI_INT]) begin
                    irq_set = 1'b1;
                end
                if ((dec.is_xfer || dec.is_nop) && c_fire[CI_BR]) begin
                    d.ptr = {q.dep[31:4], 4'b0000};
                    d.bt  = 1'b1;
                end else begin
                    d.ptr = q.ptr + OFS_NEXT;
                    d.bt  = 1'b0;
                end
                d.st = S_FETCH0;
            end
            default: d.st = S_IDLE;
        endcase

        if (wake_i) begin
            d.wake = 1'b1;
        end
        if (flush_i) begin
            d.flush = 1'b1;
        end
        d.irq = (q.irq && !irq_ack_i) || irq_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign dev_out_o  = dec.is_out;
    assign dev_last_o = dec.is_last;
    assign dev_addr_o = q.daddr;
    assign dev_len_o  = q.reqcnt;
    assign irq_o      = q.irq;
    assign status_o   = pack_status(q.active, q.dead, q.wake, q.flush, q.bt, dev_stat_i);

    // R14
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R14
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_o, dev_req_o}));

    // R3
    dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req_o && !dev_done_i) |=> (dev_req_o && $stable(dev_addr_o) && $stable(dev_len_o)));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_ack_i) |=> irq_o);

    // R4
    dead_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[14] |-> !status_o[15]);

    // R2
    start_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[15] && start_i) |=> status_o[15]);

    // R12
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DECODE && dec.is_stop && !dec.kill) |=> (!status_o[15] && !mem_req_o));

endmodule

// File: tb/desc_dma_seq_bench.sv
module desc_dma_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_ptr_i = '0;
    logic        flush_i = 1'b0;
    logic        wake_i = 1'b0;
    logic [3:0]  dev_stat_i = '0;
    logic [3:0]  int_mask_i = '0, int_val_i = '0;
    logic [3:0]  br_mask_i = '0, br_val_i = '0;
    logic [3:0]  wt_mask_i = '0, wt_val_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [3:0]  mem_be_o;
    logic [31:0] mem_rdata_i;
    logic        mem_ack_i;
    logic        dev_req_o, dev_out_o, dev_last_o;
    logic [31:0] dev_addr_o;
    logic [15:0] dev_len_o;
    logic        dev_done_i;
    logic [15:0] dev_resid_i;
    logic        irq_o;
    logic        irq_ack_i = 1'b0;
    logic [15:0] status_o;

    always #2 clk = ~clk;

    desc_dma_seq u_desc_dma_seq (.*);

    // memory model and host preload port
    logic [31:0] mem [256];
    logic        ack_q;
    logic [31:0] rdata_q;
    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0, host_data = '0;

    assign mem_ack_i   = ack_q;
    assign mem_rdata_i = rdata_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= mem_req_o && !ack_q;
            if (mem_req_o && !ack_q) begin
                rdata_q <= mem[mem_addr_o[9:2]];
                if (mem_we_o) begin
                    for (int b = 0; b < 4; b++) begin
                        if (mem_be_o[b]) mem[mem_addr_o[9:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
                    end
                end
            end
        end
        if (host_we) mem[host_addr[9:2]] <= host_data;
    end

    // device model with transfer capture
    logic        done_q;
    logic [15:0] resid_val = 16'h0005;
    int          cap_n;
    logic [31:0] cap_addr [8];
    logic [15:0] cap_len  [8];
    logic        cap_out  [8];
    logic        cap_last [8];
    int          viol;

    assign dev_done_i  = done_q;
    assign dev_resid_i = done_q ? resid_val : 16'h0;

    always @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            cap_n  <= 0;
            viol   <= 0;
        end else begin
            done_q <= dev_req_o && !done_q;
            if (dev_req_o && !done_q) begin
                cap_addr[cap_n[2:0]] <= dev_addr_o;
                cap_len[cap_n[2:0]]  <= dev_len_o;
                cap_out[cap_n[2:0]]  <= dev_out_o;
                cap_last[cap_n[2:0]] <= dev_last_o;
                cap_n <= cap_n + 1;
            end
            if ((mem_req_o && mem_addr_o[1:0] != 2'b00) || (mem_req_o && dev_req_o)) viol <= viol + 1;
        end
    end

    int checks = 0;
    int fails  = 0;
    bit done_all = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [2:0] key,
                                       input logic [1:0] im, input logic [1:0] bm, input logic [1:0] wm);
        return {op, 1'b0, key, 2'b00, im, bm, wm};
    endfunction

    task automatic poke(input logic [31:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        host_we = 1'b1; host_addr = a; host_data = v;
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic desc(input logic [31:0] a, input logic [15:0] cmd, input logic [15:0] cnt,
                        input logic [31:0] da, input logic [31:0] dep, input logic [31:0] w3);
        poke(a,      {cmd, cnt});
        poke(a + 4,  da);
        poke(a + 8,  dep);
        poke(a + 12, w3);
    endtask

    task automatic pulse_start(input logic [31:0] p);
        @(posedge clk); #1;
        start_i = 1'b1; start_ptr_i = p;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!status_o[15]) break;
        end
    endtask

    task automatic run(input logic [31:0] p);
        pulse_start(p);
        wait_idle();
    endtask

    task automatic pulse_ack();
        @(posedge clk); #1; irq_ack_i = 1'b1;
        @(posedge clk); #1; irq_ack_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_eq("R1 status", 32'(status_o), 32'h0);
        chk_eq("R1 irq", 32'(irq_o), 32'h0);
        chk_eq("R1 requests", {30'd0, mem_req_o, dev_req_o}, 32'h0);
    endtask

    task automatic t_xfer();
        desc(32'h000, mk(4'd0, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0020, 32'h1000, 32'h0, 32'hDEADBEEF);
        desc(32'h010, mk(4'd3, 3'd0, 2'd3, 2'd0, 2'd0), 16'h0008, 32'h2000, 32'h0, 32'hDEADBEEF);
        desc(32'h020, mk(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0000, 32'h0,    32'h0, 32'hDEADBEEF);
        @(posedge clk); #1; flush_i = 1'b1;
        @(posedge clk); #1; flush_i = 1'b0;
        run(32'h000);
        chk_eq("R3 xfer count", 32'(cap_n), 32'd2);
        chk_eq("R3 out addr", cap_addr[0], 32'h1000);
        chk_eq("R3 out len/dir/last", {cap_len[0], 14'd0, cap_out[0], cap_last[0]}, {16'h0020, 16'h0002});
        chk_eq("R3 in addr", cap_addr[1], 32'h2000);
        chk_eq("R3 in len/dir/last", {cap_len[1], 14'd0, cap_out[1], cap_last[1]}, {16'h0008, 16'h0001});
        chk_eq("R3 wb first", mem[8'h03], 32'h9000_0005);
        chk_eq("R11 more keeps flush", mem[8'h07], 32'h9000_0005);
        chk_eq("R12 stop no write", mem[8'h0B], 32'hDEADBEEF);
        chk_eq("R11 last clears flush", 32'(status_o), 32'h0000);
        chk_eq("R7 irq raised", 32'(irq_o), 32'h1);
        pulse_ack();
        @(negedge clk);
        chk_eq("R7 irq acked", 32'(irq_o), 32'h0);
    endtask

    task automatic t_branch();
        dev_stat_i = 4'b0001; br_mask_i = 4'b0001; br_val_i = 4'b0001;
        desc(32'h040, mk(4'd6, 3'd0, 2'd0, 2'd1, 2'd0), 16'h0, 32'h0, 32'h0000_0085, 32'h1234ABCD);
        desc(32'h050, mk(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0, 32'h0, 32'h0, 32'hDEADBEEF);
        desc(32'h080, mk(4'd6, 3'd0, 2'd0, 2'd2, 2'd0), 16'h0, 32'h0, 32'h0000_0040, 32'h1234ABCD);
        desc(32'h090, mk(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0, 32'h0, 32'h0, 32'hDEADBEEF);
        run(32'h040);
        chk_eq("R8 nop wb upper only", mem[8'h13], 32'h8001ABCD);
        chk_eq("R5 R8 branch target bt set", mem[8'h23], 32'h8801ABCD);
        chk_eq("R5 if-clear not taken", 32'(status_o), 32'h0001);
        chk_eq("R7 no irq on never", 32'(irq_o), 32'h0);
        dev_stat_i = 4'b0000; br_mask_i = 4'b0; br_val_i = 4'b0;
    endtask

    task automatic t_load();
        poke(32'h1C0, 32'hAABBCCDD);
        desc(32'h100, mk(4'd5, 3'd0, 2'd0, 2'd3, 2'd0), 16'h0002, 32'h1C3, 32'h11223344, 32'h0);
        desc(32'h110, mk(4'd5, 3'd6, 2'd0, 2'd0, 2'd0), 16'h0009, 32'h1C1, 32'h99887766, 32'h0);
        desc(32'h120, mk(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0, 32'h0, 32'h0, 32'h0);
        @(posedge clk); #1; flush_i = 1'b1;
        @(posedge clk); #1; flush_i = 1'b0;
        run(32'h100);
        chk_eq("R9 load half", mem[8'h42], 32'h1122AABB);
        chk_eq("R9 load byte", mem[8'h46], 32'h998877CC);
        chk_eq("R11 load wb with flush", mem[8'h43], 32'h9000_0000);
        chk_eq("R11 flush cleared by load", mem[8'h47], 32'h8000_0000);
        chk_eq("R9 no branch dead clear", 32'(status_o), 32'h0000);
    endtask

    task automatic t_store();
        poke(32'h1D0, 32'h0);
        poke(32'h1E0, 32'h11111111);
        desc(32'h140, mk(4'd4, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0004, 32'h1D3, 32'hCAFEF00D, 32'h0000_7777);
        desc(32'h150, mk(4'd4, 3'd6, 2'd0, 2'd0, 2'd0), 16'h0000, 32'h1E2, 32'h0000_005A, 32'h0);
        desc(32'h160, mk(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0, 32'h0, 32'h0, 32'h0);
        run(32'h140);
        chk_eq("R10 store word", mem[8'h74], 32'hCAFEF00D);
        chk_eq("R10 store byte lane", mem[8'h78], 32'h115A1111);
        chk_eq("R10 status upper half", mem[8'h53], 32'h8000_7777);
        chk_eq("R10 aux untouched", mem[8'h52], 32'hCAFEF00D);
    endtask

    task automatic t_kill();
        int n0;
        n0 = cap_n;
        desc(32'h200, mk(4'd0, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0010, 32'h0,    32'h0, 32'hDEADBEEF);
        desc(32'h210, mk(4'd2, 3'd4, 2'd0, 2'd0, 2'd0), 16'h0010, 32'h3000, 32'h0, 32'hDEADBEEF);
        desc(32'h220, mk(4'd9, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0010, 32'h3000, 32'h0, 32'hDEADBEEF);
        run(32'h200);
        chk_eq("R4 zero addr kill", {irq_o, status_o}, {1'b1, 16'h4000});
        chk_eq("R4 no write back", mem[8'h83], 32'hDEADBEEF);
        // earlier interrupt still pending; acknowledge exactly in the decode cycle
        pulse_start(32'h210);
        repeat (6) @(posedge clk);
        #1 irq_ack_i = 1'b1;
        @(posedge clk); #1 irq_ack_i = 1'b0;
        wait_idle();
        chk_eq("R7 set beats ack", 32'(irq_o), 32'h1);
        chk_eq("R4 key4 kill", 32'(status_o), 32'h4000);
        pulse_ack();
        run(32'h220);
        chk_eq("R4 bad opcode kill", {irq_o, status_o}, {1'b1, 16'h4000});
        chk_eq("R4 no device request", 32'(cap_n), 32'(n0));
        pulse_ack();
        run(32'h020);
        chk_eq("R2 start clears dead", 32'(status_o), 32'h0000);
    endtask

    task automatic t_wait();
        int n0;
        n0 = cap_n;
        wt_mask_i = 4'b0010; wt_val_i = 4'b0010; dev_stat_i = 4'b0010;
        desc(32'h240, mk(4'd6, 3'd0, 2'd0, 2'd0, 2'd1), 16'h0, 32'h0, 32'h0, 32'hDEADBEEF);
        desc(32'h250, mk(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0, 32'h0, 32'h0, 32'h0);
        pulse_start(32'h240);
        repeat (30) @(posedge clk);
        pulse_start(32'h000);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk_eq("R6 held no write", mem[8'h93], 32'hDEADBEEF);
        chk_eq("R6 still active", 32'(status_o[15]), 32'h1);
        #1 dev_stat_i = 4'b0000;
        wait_idle();
        chk_eq("R6 released write", mem[8'h93], 32'h8000BEEF);
        chk_eq("R13 restart ignored", 32'(cap_n), 32'(n0));
        chk_eq("R13 old chain intact", mem[8'h03], 32'h9000_0005);
        wt_mask_i = 4'b0; wt_val_i = 4'b0;
    endtask

    task automatic t_wake();
        @(posedge clk); #1 wake_i = 1'b1;
        @(posedge clk); #1 wake_i = 1'b0;
        @(negedge clk);
        chk_eq("R2 wake set", 32'(status_o), 32'h2000);
        run(32'h020);
        chk_eq("R2 fetch clears wake", 32'(status_o), 32'h0000);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_xfer();
        t_branch();
        t_load();
        t_store();
        t_kill();
        t_wait();
        t_wake();
        chk_eq("R14 protocol violations", 32'(viol), 32'h0);
        done_all = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_all) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule